// File: doc/BRIEF.md
# Pipelined Restoring Integer Divider

This block divides one unsigned dividend by one unsigned divisor, both W bits wide, and returns a W-bit quotient and a W-bit remainder. It does not iterate a single shift and subtract unit over many clocks. Every bit decision of the restoring method is built as its own combinational step. Each step shifts the partial remainder left and brings in the next dividend bit. It then subtracts the divisor as a trial. If that trial goes negative, the step keeps the shifted value; otherwise it keeps the difference.

The W steps are split into two halves, and a register bank follows each half. Because of this, a new operand pair can enter on every clock. Results leave in the order the operands arrived, two clocks after they were accepted. A zero divisor does not stall the pipe. It marks its own result with a flag that travels through the pipe with the data, and the arithmetic then gives an all-ones quotient. The block sits in a datapath that can produce one operand pair per clock and needs no backpressure.

Top module: `rdiv_pipe`

## Requirements
- R1: When the divisor is nonzero, out_quotient equals floor(dividend / divisor), treating both operands as unsigned.
- R2: When the divisor is nonzero, out_remainder equals dividend minus quotient times divisor, and it is strictly less than the divisor.
- R3: out_valid is high exactly two rising clock edges after in_valid was high at an edge, and low two edges after in_valid was low. One result can therefore leave on every clock.
- R4: Results appear in the order their operand pairs were accepted. Each result depends only on its own operands, including under back-to-back traffic and bubbles.
- R5: When the divisor is zero, out_div_by_zero is 1, out_quotient is all ones, and out_remainder equals the dividend.
- R6: When the divisor is nonzero, out_div_by_zero is 0.
- R7: While rst_n is low and after it is released, out_valid is 0 until a valid operand pair has passed through both stages.
- R8: Boundary operands give the exact results: a dividend below the divisor, a dividend equal to the divisor, a zero dividend, and the maximum value divided by 1 and by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| in_valid | input | 1 | Operand pair on the inputs is accepted this clock |
| in_dividend | input | W | Unsigned dividend |
| in_divisor | input | W | Unsigned divisor |
| out_valid | output | 1 | Result outputs carry a result this clock |
| out_quotient | output | W | Unsigned quotient |
| out_remainder | output | W | Unsigned remainder |
| out_div_by_zero | output | 1 | Result came from a zero divisor |

## Verification
On every cycle, the assertions check that valid moves exactly one bank per clock and that bubbles stay empty. They also check that the zero-divisor flag follows its own operand into the first bank, and that a flagged result carries an all-ones quotient. Within each step they check that the kept partial remainder stays below a nonzero divisor and that an accepted difference fits in W bits. Two things can only be shown by the bench's scenarios, where each result is compared with a reference queue: that the quotient and remainder are numerically right, and that results keep their order across back-to-back traffic, bubbles and zero divisors.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  localparam int unsigned RDIV_DEF_W = 16;

  // number of bit decisions resolved ahead of the first register bank
  function automatic int unsigned rdiv_front_steps(input int unsigned w);
    return w / 2;
  endfunction

endpackage

// File: rtl/rdiv_step.sv
// One restoring bit decision: shift, trial subtract, keep or restore.
module rdiv_step #(
  parameter int unsigned W = 16
) (
  input  logic         chk_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] q_o
);

  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         restore;

  always_comb begin
    shifted = {rem_i, q_i[W-1]};
    trial   = {1'b0, shifted} - {2'b00, d_i};
    restore = trial[W+1];
    rem_o   = restore ? shifted[W-1:0] : trial[W-1:0];
    q_o     = {q_i[W-2:0], ~restore};
  end

  always_comb begin
    if (chk_i && !restore) begin
      AST_DIFF_FITS: assert (trial[W] == 1'b0); // R2
    end
    if (chk_i && (d_i != '0) && (rem_i < d_i)) begin
      AST_REM_BOUND: assert (rem_o < d_i); // R2
    end
  end

endmodule

// File: rtl/rdiv_chain.sv
// A run of STEPS restoring decisions laid out back to back.
module rdiv_chain #(
  parameter int unsigned W     = 16,
  parameter int unsigned STEPS = 8
) (
  input  logic         chk_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] q_o
);

  logic [W-1:0] rem_w [STEPS+1];
  logic [W-1:0] q_w   [STEPS+1];

  assign rem_w[0] = rem_i;
  assign q_w[0]   = q_i;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    rdiv_step #(.W(W)) step_i (
      .chk_i (chk_i),
      .rem_i (rem_w[s]),
      .q_i   (q_w[s]),
      .d_i   (d_i),
      .rem_o (rem_w[s+1]),
      .q_o   (q_w[s+1])
    );
  end

  assign rem_o = rem_w[STEPS];
  assign q_o   = q_w[STEPS];

endmodule

// File: rtl/rdiv_bank.sv
// Pipeline register bank: valid is reset, data loads only with valid.
module rdiv_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_i,
  input  logic         dz_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic         dz_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] d_o
);

  logic         dz_nxt;
  logic [W-1:0] rem_nxt;
  logic [W-1:0] q_nxt;
  logic [W-1:0] d_nxt;

  always_comb begin
    dz_nxt  = dz_o;
    rem_nxt = rem_o;
    q_nxt   = q_o;
    d_nxt   = d_o;
    if (v_i) begin
      dz_nxt  = dz_i;
      rem_nxt = rem_i;
      q_nxt   = q_i;
      d_nxt   = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    dz_o  <= dz_nxt;
    rem_o <= rem_nxt;
    q_o   <= q_nxt;
    d_o   <= d_nxt;
  end

endmodule

// File: rtl/rdiv_pipe.sv
module rdiv_pipe
  import rdiv_pkg::*;
#(
  parameter int unsigned W = RDIV_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_dividend,
  input  logic [W-1:0] in_divisor,
  output logic         out_valid,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder,
  output logic         out_div_by_zero
);

  localparam int unsigned STEPS_A = rdiv_front_steps(W);
  localparam int unsigned STEPS_B = W - STEPS_A;

  // stage A: first half of the decisions from a zero partial remainder
  logic [W-1:0] a_rem, a_q;
  logic         a_dz;

  assign a_dz = (in_divisor == '0);

  rdiv_chain #(.W(W), .STEPS(STEPS_A)) chain_a_i (
    .chk_i (in_valid),
    .rem_i ('0),
    .q_i   (in_dividend),
    .d_i   (in_divisor),
    .rem_o (a_rem),
    .q_o   (a_q)
  );

  logic         s1_v, s1_dz;
  logic [W-1:0] s1_rem, s1_q, s1_d;

  rdiv_bank #(.W(W)) bank_a_i (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (in_valid),
    .dz_i  (a_dz),
    .rem_i (a_rem),
    .q_i   (a_q),
    .d_i   (in_divisor),
    .v_o   (s1_v),
    .dz_o  (s1_dz),
    .rem_o (s1_rem),
    .q_o   (s1_q),
    .d_o   (s1_d)
  );

  // stage B: remaining decisions
  logic [W-1:0] b_rem, b_q;

  rdiv_chain #(.W(W), .STEPS(STEPS_B)) chain_b_i (
    .chk_i (s1_v),
    .rem_i (s1_rem),
    .q_i   (s1_q),
    .d_i   (s1_d),
    .rem_o (b_rem),
    .q_o   (b_q)
  );

  logic [W-1:0] s2_d;

  rdiv_bank #(.W(W)) bank_b_i (
    .clk   (clk),
    .rst_n (rst_n),
    .v_i   (s1_v),
    .dz_i  (s1_dz),
    .rem_i (b_rem),
    .q_i   (b_q),
    .d_i   (s1_d),
    .v_o   (out_valid),
    .dz_o  (out_div_by_zero),
    .rem_o (out_remainder),
    .q_o   (out_quotient),
    .d_o   (s2_d)
  );

  // arms the timing checks one edge after reset release
  logic arm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm <= 1'b0;
    else        arm <= 1'b1;
  end

  AST_ENTER_BANK_A: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && in_valid) |=> s1_v); // R3
  AST_ENTER_BANK_B: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && s1_v) |=> out_valid); // R3
  AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !s1_v) |=> !out_valid); // R3
  AST_DZ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && in_valid) |=> (s1_dz == $past(in_divisor == '0))); // R6
  AST_DZ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_div_by_zero) |-> (&out_quotient)); // R5
  AST_REM_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_div_by_zero) |-> (out_remainder < s2_d)); // R2

endmodule

// File: tb/rdiv_pipe_tb.sv
module rdiv_pipe_tb_top;

  localparam int unsigned W      = 16;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned N_RAND = 3000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_dividend = '0;
  logic [W-1:0] in_divisor = '0;
  logic         out_valid;
  logic [W-1:0] out_quotient;
  logic [W-1:0] out_remainder;
  logic         out_div_by_zero;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdiv_pipe #(.W(W)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_dividend     (in_dividend),
    .in_divisor      (in_divisor),
    .out_valid       (out_valid),
    .out_quotient    (out_quotient),
    .out_remainder   (out_remainder),
    .out_div_by_zero (out_div_by_zero)
  );

  typedef struct packed {
    logic         dz;
    logic [W-1:0] q;
    logic [W-1:0] r;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  logic vh0 = 1'b0, vh1 = 1'b0;

  function automatic exp_t ref_div(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    if (b == '0) begin
      e.dz = 1'b1; e.q = '1; e.r = a;
    end else begin
      e.dz = 1'b0; e.q = a / b; e.r = a % b;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // compare outputs of the pair driven two cycles ago, then drive a new one
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    @(negedge clk);
    check(out_valid == vh1, "R3 out_valid latency", 64'(out_valid), 64'(vh1));
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 result without operands", 64'd1, 64'd0);
      end else begin
        e = exp_q.pop_front();
        if (e.dz) begin
          check(out_div_by_zero == 1'b1, "R5 flag", 64'(out_div_by_zero), 64'd1);
          check(out_quotient == e.q, "R5 quotient", 64'(out_quotient), 64'(e.q));
          check(out_remainder == e.r, "R5 remainder", 64'(out_remainder), 64'(e.r));
        end else begin
          check(out_div_by_zero == 1'b0, "R6 flag", 64'(out_div_by_zero), 64'd0);
          check(out_quotient == e.q, "R1 R4 quotient", 64'(out_quotient), 64'(e.q));
          check(out_remainder == e.r, "R2 R4 remainder", 64'(out_remainder), 64'(e.r));
        end
      end
    end
    vh1 = vh0;
    vh0 = v;
    in_valid    = v;
    in_dividend = a;
    in_divisor  = b;
    if (v) exp_q.push_back(ref_div(a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] a, b;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid after release", 64'(out_valid), 64'd0);

    // directed corners, back to back (R8)
    step(1'b1, '1, 16'd1);
    step(1'b1, '1, '1);
    step(1'b1, 16'd5, 16'd9);
    step(1'b1, 16'd9, 16'd9);
    step(1'b1, '0, 16'd7);
    step(1'b1, 16'h1234, '0);
    step(1'b1, '0, '0);
    step(1'b1, 16'd7, 16'd8);
    step(1'b0, 16'hdead, '0);
    step(1'b1, 16'd9, 16'd3);
    step(1'b0, 16'hbeef, 16'd1);
    step(1'b0, 16'h0, 16'd2);
    step(1'b1, 16'h8000, 16'h8001);
    step(1'b1, 16'hfffe, 16'h7fff);

    // random traffic with bubbles and zero divisors (R1 R2 R4 R5 R6)
    for (int i = 0; i < N_RAND; i++) begin
      a = W'($urandom);
      case ($urandom % 16)
        0:       b = '0;
        1, 2, 3: b = W'($urandom % 16);
        4:       b = a;
        default: b = W'($urandom);
      endcase
      step(($urandom % 8) != 0, a, b);
    end

    repeat (4) step(1'b0, '0, '0);
    check(exp_q.size() == 0, "R4 all results delivered", 64'(exp_q.size()), 64'd0);
    done = 1;
    finish_run();
  end

endmodule